// File: doc/BRIEF.md
# Sixteenth-Second Watchdog Timer

This block is a programmable watchdog. It counts an interval in sixteenths of a second, paced by an external 16 Hz tick strobe. Software sets the interval and the expiry action with one byte written to the control register. It re-arms the watchdog either by writing that byte again or by reading the status register. If the watchdog is not re-armed in time, it sets a status flag and then does one of two things: it raises a one-cycle reset request, together with a pulse that clears the century-related bit of the neighbouring calendar, or it pulses an interrupt line.

The control byte has three fields:
- bits [1:0]: resolution code R.
- bits [6:2]: multiplier M.
- bit 7: steering bit.

The timeout is M × 4^R ticks. A state machine holds the counting state. There are three states:
- IDLE: disabled. The block is in this state after reset and after it is armed with M = 0.
- COUNT: the counter is running down.
- HALT: the watchdog has expired and the counter is stopped.

The transitions are:
- ARM: any state to COUNT, when the block is re-armed with a non-zero interval.
- DISARM: any state to IDLE, when the block is re-armed with a zero interval.
- STEP: COUNT to COUNT, on a tick while the counter is above 1.
- EXPIRE: COUNT to HALT, on a tick while the counter equals 1.

Top module: `wdog_sixteenth`

## Requirements
- R1: The control byte holds the resolution code R in bits [1:0] and the multiplier M in bits [6:2]. Expiry happens on the (M × 4^R)-th tick after the most recent arming. The action outputs pulse in the clock cycle that follows the clock edge at which that tick was sampled.
- R2: A write to address 0 stores the byte, which then reads back at address 0. It clears the flag and restarts the countdown from the new interval.
- R3: A read at address 1 returns the flag in bit 7 and zeros in bits [6:0]. It re-arms the countdown from the stored control byte and clears the flag after the read.
- R4: On expiry, the flag (status bit 7) becomes 1.
- R5: If steering bit 7 is 1 at expiry, `rst_req` and `century_clr` pulse high for exactly one cycle, and the control byte becomes 0x00.
- R6: If steering bit 7 is 0 at expiry, `irq` pulses high for exactly one cycle, and the control byte keeps its value.
- R7: Writes to address 1 are ignored. They leave both the flag and the countdown unchanged.
- R8: A multiplier of zero disables the watchdog. No expiry occurs, however many ticks arrive.
- R9: After expiry the counter stays stopped. No further pulse occurs until the block is re-armed.
- R10: A control write in the same cycle as a tick takes priority. That tick is not counted against either the old interval or the new one.
- R11: The synchronous reset clears the control byte, the flag and the counter, and leaves every output pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16hz | input | 1 | One-cycle strobe, sixteen per second |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Data of the addressed register |
| irq | output | 1 | One-cycle interrupt pulse on expiry (steering 0) |
| rst_req | output | 1 | One-cycle reset request on expiry (steering 1) |
| century_clr | output | 1 | One-cycle pulse that clears the neighbour's century-related bit |

## Verification
The embedded assertions check several properties on every cycle:
- the action pulses last exactly one cycle and are mutually exclusive;
- the counter steps down by one per tick while in COUNT;
- an expiry always sets the flag, and a steered expiry always clears the control byte;
- a zero interval always lands in IDLE;
- a status write never moves the flag.

Other behaviour needs the bench's scenarios, which track a reference model of the countdown:
- the exact tick on which expiry falls for each resolution code;
- re-arming by a status read, and the read-then-clear order of the flag;
- priority of a write over a coincident tick;
- silence after expiry and with a zero multiplier.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // register port selects
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_STAT = 1'b1;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_HALT  = 2'd2
    } wd_state_t;

endpackage

// File: rtl/wdog_interval.sv
module wdog_interval #(
    parameter int RES_W  = 2,
    parameter int MULT_W = 5,
    localparam int DATA_W = RES_W + MULT_W + 1,
    localparam int NRES   = 1 << RES_W,
    localparam int CNT_W  = MULT_W + 2 * (NRES - 1)
) (
    input  logic [DATA_W-1:0] cfg,
    output logic [CNT_W-1:0]  ticks
);

    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
    logic [CNT_W-1:0]  scaled [NRES];

    assign mult = cfg[RES_W +: MULT_W];
    assign res  = cfg[RES_W-1:0];

    // one pre-shifted candidate per resolution code, power of four each step
    for (genvar g = 0; g < NRES; g++) begin : g_scale
        assign scaled[g] = CNT_W'(mult) << (2 * g);
    end

    assign ticks = scaled[res];

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int RES_W  = 2,
    parameter int MULT_W = 5,
    localparam int DATA_W = RES_W + MULT_W + 1,
    localparam int STEER  = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              flag_q,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              arm,
    output logic [DATA_W-1:0] arm_cfg
);

    logic wr_ctrl;
    logic rd_stat;

    assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
    assign rd_stat = reg_rd && (reg_addr == SEL_STAT);

    assign arm     = wr_ctrl || rd_stat;
    assign arm_cfg = wr_ctrl ? reg_wdata : ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata;
            flag_q <= 1'b0;
        end else if (rd_stat) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
            if (ctrl_q[STEER]) begin
                ctrl_q <= '0;
            end
        end
    end

    always_comb begin
        if (reg_addr == SEL_STAT) begin
            reg_rdata = {flag_q, {(DATA_W-1){1'b0}}};
        end else begin
            reg_rdata = ctrl_q;
        end
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);

    // R5
    steer_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q[STEER]) |=> (ctrl_q == '0));

    // R7
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == SEL_STAT && !expire && !reg_rd) |=> $stable(flag_q));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int RES_W  = 2,
    parameter int MULT_W = 5,
    localparam int NRES  = 1 << RES_W,
    localparam int CNT_W = MULT_W + 2 * (NRES - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_ticks,
    input  logic             steer,
    output logic             expire,
    output logic             irq_q,
    output logic             rst_req_q,
    output logic             cent_clr_q
);

    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (arm) begin
            cnt_d   = arm_ticks;
            state_d = (arm_ticks == '0) ? WD_IDLE : WD_COUNT;
        end else begin
            unique case (state_q)
                WD_IDLE: begin
                    state_d = WD_IDLE;
                end
                WD_COUNT: begin
                    if (tick) begin
                        if (cnt_q == CNT_W'(1)) begin
                            expire  = 1'b1;
                            cnt_d   = '0;
                            state_d = WD_HALT;
                        end else begin
                            cnt_d = cnt_q - CNT_W'(1);
                        end
                    end
                end
                WD_HALT: begin
                    state_d = WD_HALT;
                end
                default: begin
                    state_d = WD_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // action outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q      <= 1'b0;
            rst_req_q  <= 1'b0;
            cent_clr_q <= 1'b0;
        end else begin
            irq_q      <= expire && !steer;
            rst_req_q  <= expire && steer;
            cent_clr_q <= expire && steer;
        end
    end

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R5
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |=> !rst_req_q);

    // R5
    action_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_q && rst_req_q));

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_COUNT && !arm && tick && cnt_q > CNT_W'(1))
            |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R8
    zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (arm && arm_ticks == '0) |=> (state_q == WD_IDLE));

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_HALT) |-> !expire);

endmodule

// File: rtl/wdog_sixteenth.sv
module wdog_sixteenth
    import wdog_pkg::*;
#(
    parameter int RES_W  = 2,
    parameter int MULT_W = 5,
    localparam int DATA_W = RES_W + MULT_W + 1,
    localparam int NRES   = 1 << RES_W,
    localparam int CNT_W  = MULT_W + 2 * (NRES - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_16hz,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              rst_req,
    output logic              century_clr
);

    logic [DATA_W-1:0] ctrl_q;
    logic              flag_q;
    logic              arm;
    logic [DATA_W-1:0] arm_cfg;
    logic [CNT_W-1:0]  arm_ticks;
    logic              expire;

    wdog_regs #(.RES_W(RES_W), .MULT_W(MULT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .expire    (expire),
        .ctrl_q    (ctrl_q),
        .flag_q    (flag_q),
        .reg_rdata (reg_rdata),
        .arm       (arm),
        .arm_cfg   (arm_cfg)
    );

    wdog_interval #(.RES_W(RES_W), .MULT_W(MULT_W)) u_ival (
        .cfg   (arm_cfg),
        .ticks (arm_ticks)
    );

    wdog_fsm #(.RES_W(RES_W), .MULT_W(MULT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_16hz),
        .arm        (arm),
        .arm_ticks  (arm_ticks),
        .steer      (ctrl_q[DATA_W-1]),
        .expire     (expire),
        .irq_q      (irq),
        .rst_req_q  (rst_req),
        .cent_clr_q (century_clr)
    );

    // R4
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q);

    // R5
    rst_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (flag_q && ctrl_q == '0 && century_clr));

endmodule

// File: tb/sim_wdog_sixteenth.sv
module sim_wdog_sixteenth;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16hz = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, rst_req, century_clr;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_sixteenth u0 (
        .clk         (clk),
        .rst         (rst),
        .tick_16hz   (tick_16hz),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq         (irq),
        .rst_req     (rst_req),
        .century_clr (century_clr)
    );

    typedef struct {
        bit is_rst;
        int cyc;
    } ev_t;

    ev_t exp_q[$];
    int  n_checks = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  done = 1'b0;

    // reference model
    logic [7:0] m_ctrl = 8'h00;
    bit         m_flag = 1'b0;
    int         m_cnt = 0;
    bit         m_run = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic m_arm(input logic [7:0] cfg);
        m_cnt  = int'(cfg[6:2]) << (2 * int'(cfg[1:0]));
        m_run  = (m_cnt != 0);
        m_flag = 1'b0;
    endtask

    task automatic m_tick();
        if (m_run) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_run  = 1'b0;
                m_flag = 1'b1;
                exp_q.push_back('{is_rst: m_ctrl[7], cyc: cyc + 1});
                if (m_ctrl[7]) m_ctrl = 8'h00;
            end
        end
    endtask

    task automatic do_write(input logic a, input logic [7:0] d, input bit with_tick);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick_16hz = with_tick;
        if (a == 1'b0) begin
            m_ctrl = d;
            m_arm(d);
        end else if (with_tick) begin
            m_tick();
        end
        @(negedge clk);
        reg_wr = 1'b0; tick_16hz = 1'b0;
    endtask

    task automatic do_read(input logic a, input string tag);
        int exp;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        exp = (a == 1'b0) ? int'(m_ctrl) : (m_flag ? 8'h80 : 8'h00);
        check(reg_rdata == exp[7:0], tag, reg_rdata, exp);
        if (a == 1'b1) m_arm(m_ctrl);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_16hz = 1'b1;
            m_tick();
            @(negedge clk);
            tick_16hz = 1'b0;
        end
    endtask

    // monitor: pops expected action pulses
    always @(negedge clk) begin
        if (!rst && !done && (irq || rst_req || century_clr)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected pulse", {irq, rst_req, century_clr}, 0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                check(cyc == e.cyc, "R1 pulse cycle", cyc, e.cyc);
                check(rst_req == e.is_rst && irq == !e.is_rst, e.is_rst ? "R5 reset kind" : "R6 irq kind",
                      {irq, rst_req}, e.is_rst ? 1 : 2);
                check(century_clr == rst_req, "R5 century pulse", century_clr, rst_req);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(irq == 1'b0 && rst_req == 1'b0 && century_clr == 1'b0, "R11 outputs", {irq, rst_req, century_clr}, 0);
        rst = 1'b0;
        do_read(1'b0, "R11 ctrl");
        do_read(1'b1, "R11 flag");
        ticks(4);

        // R1 shortest interval, R6 irq steering, R2 readback
        do_write(1'b0, 8'h04, 1'b0);
        do_read(1'b0, "R2 readback");
        ticks(2);
        do_read(1'b1, "R4 flag after expiry");
        do_read(1'b1, "R3 flag cleared by read");

        // R1 M=3 R=1 -> 12 ticks
        do_write(1'b0, 8'h0D, 1'b0);
        ticks(11);
        do_read(1'b0, "R6 ctrl kept before expiry");
        do_write(1'b0, 8'h0D, 1'b0);
        ticks(12);
        do_read(1'b0, "R6 ctrl kept");
        // R9 halted: no more pulses
        ticks(20);

        // R7 status write ignored (flag stays set, no re-arm)
        do_write(1'b1, 8'h00, 1'b0);
        ticks(3);
        do_read(1'b1, "R7 flag survives status write");

        // R5 steering: M=2 R=2 -> 32 ticks
        do_write(1'b0, 8'h8A, 1'b0);
        ticks(33);
        do_read(1'b0, "R5 ctrl cleared");

        // R8 zero multiplier
        do_write(1'b0, 8'h03, 1'b0);
        ticks(30);
        do_read(1'b1, "R8 no flag");

        // R3 re-arm by status read: M=2 R=0
        do_write(1'b0, 8'h08, 1'b0);
        ticks(1);
        do_read(1'b1, "R3 re-arm read");
        ticks(1);
        do_read(1'b0, "R3 still counting");
        ticks(2);

        // R2 write mid-count restarts
        do_write(1'b0, 8'h0C, 1'b0);
        ticks(2);
        do_write(1'b0, 8'h0C, 1'b0);
        ticks(3);

        // R10 write coincident with tick: M=1 R=0, the tick is dropped
        do_write(1'b0, 8'h04, 1'b1);
        do_read(1'b1, "R10 no expiry on coincident tick");
        ticks(1);

        // R1 largest interval with reset steering: M=31 R=3 -> 1984 ticks
        do_write(1'b0, 8'hFF, 1'b0);
        ticks(1983);
        do_read(1'b0, "R1 no early expiry");
        do_write(1'b0, 8'hFF, 1'b0);
        ticks(1985);
        do_read(1'b0, "R5 ctrl cleared after max interval");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R1 all expected pulses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule